// File: doc/BRIEF.md
# Multi-Flow Two-Symbol Signature Matcher

This block scans many interleaved traffic flows for a small set of byte-level signatures that have been reduced to a two-symbol alphabet. The three signatures are `abb`, `aabb` and `baaab`. They are folded into one combined expression, `(a|b)*(abb|a+b)`, and run as a single four-state deterministic automaton.

Each input beat carries a flow identifier and one symbol. The block keeps the automaton state of every flow in an on-chip context table. For each beat it loads the state of that flow, advances it by one symbol and stores it back. Because each flow has its own state, a flow's stream continues across packet boundaries and across beats from other flows that arrive in between.

When a flow enters an accepting state, the block emits a match event tagged with the flow identifier. The match output has a valid/ready handshake. A downstream consumer that holds the match back stalls the input side. A clear command returns every flow to the idle state.

Top module: `sig_flow_matcher`

## Requirements
- R1: After reset, `match_valid` is 0, `in_ready` is 1 (with `ctx_clear` low), and every flow starts in the idle state S0.
- R2: Symbol encoding is 0 = `a` and 1 = `b`. The states are S0 (idle), S1 (last symbol `a`), S2 (suffix `ab`) and S3 (suffix `abb`). On `a`, every state moves to S1. On `b`, the moves are S0→S0, S1→S2, S2→S3 and S3→S0.
- R3: A beat accepted on clock edge e whose transition lands in S2 or S3 sets `match_valid` to 1 after edge e+1, with `match_flow` equal to the beat's flow. Any other transition produces no match event.
- R4: Flows are independent. Beats from different flows may be interleaved in any order, and each flow advances only on its own beats.
- R5: Two beats of the same flow on consecutive cycles are processed in sequence. The second beat sees the state that the first beat produced.
- R6: While `match_valid` is 1 and `match_ready` is 0, `in_ready` is 0, `match_valid` and `match_flow` hold, and no flow state changes.
- R7: In a cycle with `ctx_clear` high, `in_ready` is 0 and every flow returns to S0. The beat accepted in the previous cycle is discarded, producing neither a match nor a state update.
- R8: With no stall and no clear, `in_ready` stays 1, so one beat is accepted on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted this cycle |
| in_flow | input | K | Flow identifier of the beat |
| in_sym | input | 1 | Symbol, 0 = a, 1 = b |
| ctx_clear | input | 1 | Return all flows to S0 |
| match_valid | output | 1 | Match event present |
| match_ready | input | 1 | Consumer takes the match event |
| match_flow | output | K | Flow that reached an accepting state |

## Verification
The bench drives back-to-back beats on one flow, because a design without forwarding would read the stale stored state and miss `abb` or report `ab` twice. It interleaves flows that share only a few identifiers, together with the largest identifier. This catches state that leaks between flows or a wrongly decoded index. It withholds `match_ready` at random, which exposes a design that overwrites a held event or advances a flow during a stall. It also issues clears with a beat in flight, which exposes a design that lets that beat write back a pre-clear state.

// File: rtl/sig_flow_matcher.sv
module sig_flow_matcher #(
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [K-1:0] in_flow,
  input  logic         in_sym,
  input  logic         ctx_clear,
  output logic         match_valid,
  input  logic         match_ready,
  output logic [K-1:0] match_flow
);
  localparam int DEPTH = 1 << K;

  typedef enum logic [1:0] {S0, S1, S2, S3} st_t;

  st_t          ctx [DEPTH];
  logic         s1_valid;
  logic [K-1:0] s1_flow;
  logic         s1_sym;
  st_t          s1_state;
  st_t          nxt;
  logic         stall;
  logic         fwd;

  assign stall    = match_valid && !match_ready;
  assign in_ready = !ctx_clear && !stall;
  assign fwd      = s1_valid && (s1_flow == in_flow);

  always_comb begin
    if (!s1_sym) nxt = S1;
    else begin
      case (s1_state)
        S1:      nxt = S2;
        S2:      nxt = S3;
        default: nxt = S0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctx[i] <= S0;
      s1_valid    <= 1'b0;
      s1_flow     <= '0;
      s1_sym      <= 1'b0;
      s1_state    <= S0;
      match_valid <= 1'b0;
      match_flow  <= '0;
    end else if (ctx_clear) begin
      for (int i = 0; i < DEPTH; i++) ctx[i] <= S0;
      s1_valid <= 1'b0;
      if (!stall) match_valid <= 1'b0;
    end else if (!stall) begin
      if (s1_valid) ctx[s1_flow] <= nxt;
      match_valid <= s1_valid && nxt[1];
      match_flow  <= s1_flow;
      s1_valid    <= in_valid;
      if (in_valid) begin
        s1_flow  <= in_flow;
        s1_sym   <= in_sym;
        s1_state <= fwd ? nxt : ctx[in_flow];
      end
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && !match_ready) |=> (match_valid && $stable(match_flow)));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !ctx_clear) |=> ($stable(s1_flow) && $stable(s1_state) && $stable(s1_valid)));

  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_clear |=> !s1_valid);

  assert_clear_ctx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_clear |=> (ctx[0] == S0 && ctx[DEPTH-1] == S0));

  assert_match_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_valid) |-> $past(s1_valid));
endmodule

// File: tb/sig_flow_matcher_test.sv
module sig_flow_matcher_test;
  localparam int K = 8;
  localparam int DEPTH = 1 << K;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [K-1:0] in_flow = '0;
  logic         in_sym = 1'b0;
  logic         ctx_clear = 1'b0;
  logic         match_valid;
  logic         match_ready = 1'b1;
  logic [K-1:0] match_flow;

  int total = 0;
  int bad = 0;

  int ref_st [DEPTH];
  bit e_mv = 0;
  int e_mf = 0;
  bit p_v = 0;
  int p_f = 0;
  bit p_s = 0;

  always #5 clk = ~clk;

  sig_flow_matcher #(.K(K)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_flow(in_flow), .in_sym(in_sym), .ctx_clear(ctx_clear),
    .match_valid(match_valid), .match_ready(match_ready), .match_flow(match_flow)
  );

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: run did not finish got 0 exp 1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int adv(int s, bit b);
    if (!b) return 1;
    case (s)
      1: return 2;
      2: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int got, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  task automatic beat(bit v, int f, bit s, bit clr, bit mrdy, string tag);
    bit exp_rdy;
    bit stall;
    int ns;
    in_valid = v; in_flow = f[K-1:0]; in_sym = s; ctx_clear = clr; match_ready = mrdy;
    #1;
    stall = e_mv && !mrdy;
    exp_rdy = !clr && !stall;
    chk(in_ready == exp_rdy, clr ? "R7" : (stall ? "R6" : "R8"), "in_ready", in_ready, exp_rdy);
    @(posedge clk);
    if (clr) begin
      p_v = 0;
      foreach (ref_st[i]) ref_st[i] = 0;
      if (!stall) e_mv = 0;
    end else if (!stall) begin
      if (p_v) begin
        ns = adv(ref_st[p_f], p_s);
        ref_st[p_f] = ns;
        e_mv = (ns >= 2);
        e_mf = p_f;
      end else e_mv = 0;
      p_v = v; p_f = f; p_s = s;
    end
    @(negedge clk);
    chk(match_valid == e_mv, tag, "match_valid", match_valid, e_mv);
    if (e_mv) chk(match_flow == e_mf[K-1:0], tag, "match_flow", match_flow, e_mf);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) beat(0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    foreach (ref_st[i]) ref_st[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(match_valid == 1'b0, "R1", "match_valid after reset", match_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    beat(1, 9, 1, 0, 1, "R1");
    idle(2, "R1");

    // R2 / R3: each signature on its own flow, with gaps between symbols
    beat(1, 5, 0, 0, 1, "R2"); idle(1, "R2");
    beat(1, 5, 1, 0, 1, "R3"); idle(1, "R3");
    beat(1, 5, 1, 0, 1, "R3"); idle(1, "R3");
    beat(1, 5, 1, 0, 1, "R2"); idle(2, "R2");
    beat(1, 6, 0, 0, 1, "R2"); beat(1, 6, 0, 0, 1, "R2");
    beat(1, 6, 1, 0, 1, "R3"); beat(1, 6, 1, 0, 1, "R3"); idle(2, "R3");
    beat(1, 7, 1, 0, 1, "R2"); beat(1, 7, 0, 0, 1, "R2"); beat(1, 7, 0, 0, 1, "R2");
    beat(1, 7, 0, 0, 1, "R2"); beat(1, 7, 1, 0, 1, "R3"); idle(2, "R3");

    // R4: interleaved flows including the top identifier
    beat(1, 1, 0, 0, 1, "R4"); beat(1, 255, 0, 0, 1, "R4");
    beat(1, 1, 1, 0, 1, "R4"); beat(1, 255, 1, 0, 1, "R4");
    beat(1, 2, 1, 0, 1, "R4"); beat(1, 255, 1, 0, 1, "R4");
    idle(2, "R4");

    // R5: back-to-back beats on one flow
    beat(1, 20, 0, 0, 1, "R5"); beat(1, 20, 1, 0, 1, "R5");
    beat(1, 20, 1, 0, 1, "R5"); beat(1, 20, 1, 0, 1, "R5");
    beat(1, 20, 0, 0, 1, "R5"); beat(1, 20, 1, 0, 1, "R5");
    idle(2, "R5");

    // R6: match held under backpressure
    beat(1, 30, 0, 0, 1, "R6"); beat(1, 30, 1, 0, 1, "R6");
    beat(1, 31, 0, 0, 0, "R6"); beat(1, 31, 1, 0, 0, "R6");
    beat(1, 31, 1, 0, 0, "R6"); beat(1, 31, 1, 0, 1, "R6");
    beat(1, 30, 1, 0, 0, "R6"); beat(0, 0, 0, 0, 1, "R6");
    idle(3, "R6");

    // R7: clear with a beat in flight; flow 3 would match on b if not cleared
    beat(1, 3, 0, 0, 1, "R7"); beat(1, 4, 0, 0, 1, "R7");
    beat(0, 0, 0, 1, 1, "R7");
    beat(1, 3, 1, 0, 1, "R7"); beat(1, 4, 1, 0, 1, "R7");
    idle(2, "R7");

    // R4 / R8: long mixed stream with stalls and rare clears
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 4) != 0;
      int f = (($urandom % 16) == 0) ? 255 : int'($urandom % 4);
      bit s = bit'($urandom % 2);
      bit c = ($urandom % 150) == 0;
      bit r = ($urandom % 4) != 0;
      beat(v, f, s, c, r, "R4");
    end
    idle(3, "R8");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule